// File: doc/BRIEF.md
# Receive FIFO with Service Handshake

This block is a small receive queue that sits in front of the regular mailboxes of a bus controller. Each received frame arrives as a control/status word, an identifier and a data word, and is pushed when the matching engine performs a move-in. The block also holds an eight-entry table of acceptance identifiers. The block exposes this table to the matching engine but does no comparison itself. The enable bit and the table can be changed only while the controller is frozen.

Software services the queue through the frames-available interrupt. The oldest unread frame is always visible on the head outputs. Reading the status and identifier words is optional. Clearing the interrupt is the step that releases the head entry and exposes the next one. A full flag tells the matching engine to look for a regular mailbox instead. An occupancy count is also provided.

Top module: `rx_fifo_svc`

## Requirements
- R1: After reset the queue is empty (occupancy 0), `fifo_en`, `frames_avail` and `fifo_full` are low, and every acceptance table entry is zero.
- R2: A write to the enable bit (`cfg_en_we`) takes effect at the next clock edge only while `frozen` is high. Outside freeze mode it is ignored and `fifo_en` keeps its value.
- R3: A write to table entry `cfg_id_sel` (0 to 7) takes effect only while `frozen` is high. Entry k appears on `acc_ids[k*ID_W +: ID_W]`.
- R4: A move-in (`mv_push`) while enabled and not full stores the frame and raises occupancy by one. A move-in while disabled is ignored.
- R5: `frames_avail` is high exactly when at least one frame is unread.
- R6: The head outputs show the oldest unread frame. `irq_clr` with a frame present removes it at the next edge and exposes the next frame, in arrival order.
- R7: `irq_clr` on an empty queue has no effect.
- R8: `fifo_full` is high when occupancy equals DEPTH (6 by default). A move-in while full, without a pop in the same cycle, is dropped and the stored frames do not change.
- R9: A move-in and a pop in the same cycle are both performed and occupancy is unchanged. This holds at every occupancy level, including full.
- R10: Writing the enable bit to 0 while frozen discards all stored frames, so occupancy becomes 0.
- R11: `occupancy` counts the unread frames, from 0 to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frozen | input | 1 | Controller freeze mode; gates all configuration writes |
| cfg_en_we | input | 1 | Write strobe for the enable bit |
| cfg_en_val | input | 1 | Enable value to write |
| cfg_id_we | input | 1 | Write strobe for an acceptance table entry |
| cfg_id_sel | input | SEL_W (3) | Table entry index |
| cfg_id_val | input | ID_W (29) | Identifier to store |
| acc_ids | output | TABLE_N*ID_W (232) | Flattened acceptance table for the matching engine |
| fifo_en | output | 1 | Queue enabled |
| mv_push | input | 1 | Move-in strobe from the matching engine |
| mv_cs | input | CS_W (16) | Control/status word of the incoming frame |
| mv_id | input | ID_W (29) | Identifier of the incoming frame |
| mv_data | input | DATA_W (64) | Data word of the incoming frame |
| head_cs | output | CS_W (16) | Control/status word of the oldest frame |
| head_id | output | ID_W (29) | Identifier of the oldest frame |
| head_data | output | DATA_W (64) | Data word of the oldest frame |
| irq_clr | input | 1 | Interrupt clear; pops the head entry |
| frames_avail | output | 1 | Frames-available interrupt |
| fifo_full | output | 1 | Queue full; matching must use a regular mailbox |
| occupancy | output | CNT_W (3) | Number of unread frames |

## Verification
The hardest case to reach is a move-in and an interrupt clear in the same cycle while the queue is full. Here the push may only be accepted because of the pop, and the head pointer wraps at a depth that is not a power of two. The bench fills the queue to every level from one to six and applies a simultaneous push and pop at each level. It also runs the pointers through several wraps, so the sequence numbers must stay in order as the storage index crosses the last slot. A reference queue of sequence numbers predicts the head frame, whose words are computed from the sequence number.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   localparam int RXF_TABLE_ENTRIES = 8;

   typedef enum logic [1:0] {
      RXF_OP_IDLE = 2'd0,
      RXF_OP_PUSH = 2'd1,
      RXF_OP_POP  = 2'd2,
      RXF_OP_BOTH = 2'd3
   } rxf_op_e;

endpackage

// File: rtl/rxf_cfg.sv
module rxf_cfg #(
   parameter int TABLE_N = 8,
   parameter int ID_W    = 29,
   parameter int SEL_W   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      frozen,
   input  logic                      en_we,
   input  logic                      en_val,
   input  logic                      id_we,
   input  logic [SEL_W-1:0]          id_sel,
   input  logic [ID_W-1:0]           id_val,
   output logic                      fifo_en,
   output logic                      flush,
   output logic [TABLE_N*ID_W-1:0]   ids
);

   logic en_wr_ok;
   assign en_wr_ok = frozen && en_we;
   assign flush    = en_wr_ok && !en_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fifo_en <= 1'b0;
      else if (en_wr_ok) fifo_en <= en_val;
   end

   for (genvar k = 0; k < TABLE_N; k++) begin : g_entry
      logic [ID_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (frozen && id_we && (id_sel == SEL_W'(k)))
            slot_q <= id_val;
      end
      assign ids[k*ID_W +: ID_W] = slot_q;
   end

endmodule

// File: rtl/rxf_store.sv
module rxf_store
   import rxf_pkg::*;
#(
   parameter int DEPTH   = 6,
   parameter int FRAME_W = 109,
   parameter int CNT_W   = 3,
   parameter int PTR_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               flush,
   input  logic               push,
   input  logic               pop_req,
   input  logic [FRAME_W-1:0] frame_in,
   output logic [FRAME_W-1:0] head,
   output logic [CNT_W-1:0]   count,
   output logic               full,
   output logic               avail
);

   logic [FRAME_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]   wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic               do_pop, do_push;
   rxf_op_e            op;

   assign full   = (count == CNT_W'(DEPTH));
   assign avail  = (count != '0);
   assign do_pop = pop_req && avail;
   assign do_push = push && en && (!full || do_pop);
   assign op     = rxf_op_e'({do_pop, do_push});

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= frame_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         case (op)
            RXF_OP_PUSH: begin
               wr_ptr <= wr_nxt;
               count  <= count + 1'b1;
            end
            RXF_OP_POP: begin
               rd_ptr <= rd_nxt;
               count  <= count - 1'b1;
            end
            RXF_OP_BOTH: begin
               wr_ptr <= wr_nxt;
               rd_ptr <= rd_nxt;
            end
            default: ;
         endcase
      end
   end

   assign head = mem[rd_ptr];

endmodule

// File: rtl/rx_fifo_svc.sv
module rx_fifo_svc
   import rxf_pkg::*;
#(
   parameter int CS_W    = 16,
   parameter int ID_W    = 29,
   parameter int DATA_W  = 64,
   parameter int DEPTH   = 6,
   parameter int TABLE_N = RXF_TABLE_ENTRIES,
   localparam int SEL_W  = $clog2(TABLE_N),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frozen,
   input  logic                    cfg_en_we,
   input  logic                    cfg_en_val,
   input  logic                    cfg_id_we,
   input  logic [SEL_W-1:0]        cfg_id_sel,
   input  logic [ID_W-1:0]         cfg_id_val,
   output logic [TABLE_N*ID_W-1:0] acc_ids,
   output logic                    fifo_en,
   input  logic                    mv_push,
   input  logic [CS_W-1:0]         mv_cs,
   input  logic [ID_W-1:0]         mv_id,
   input  logic [DATA_W-1:0]       mv_data,
   output logic [CS_W-1:0]         head_cs,
   output logic [ID_W-1:0]         head_id,
   output logic [DATA_W-1:0]       head_data,
   input  logic                    irq_clr,
   output logic                    frames_avail,
   output logic                    fifo_full,
   output logic [CNT_W-1:0]        occupancy
);

   localparam int PTR_W   = $clog2(DEPTH);
   localparam int FRAME_W = CS_W + ID_W + DATA_W;

   if (DEPTH < 2) begin : g_bad_depth
      $error("rx_fifo_svc: DEPTH must be at least 2");
   end
   if (TABLE_N < 2) begin : g_bad_table
      $error("rx_fifo_svc: TABLE_N must be at least 2");
   end
   if (CS_W < 1 || ID_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("rx_fifo_svc: word widths must be positive");
   end

   logic               flush;
   logic [FRAME_W-1:0] head_frame;

   rxf_cfg #(
      .TABLE_N (TABLE_N),
      .ID_W    (ID_W),
      .SEL_W   (SEL_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .frozen  (frozen),
      .en_we   (cfg_en_we),
      .en_val  (cfg_en_val),
      .id_we   (cfg_id_we),
      .id_sel  (cfg_id_sel),
      .id_val  (cfg_id_val),
      .fifo_en (fifo_en),
      .flush   (flush),
      .ids     (acc_ids)
   );

   rxf_store #(
      .DEPTH   (DEPTH),
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W),
      .PTR_W   (PTR_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (fifo_en),
      .flush    (flush),
      .push     (mv_push),
      .pop_req  (irq_clr),
      .frame_in ({mv_cs, mv_id, mv_data}),
      .head     (head_frame),
      .count    (occupancy),
      .full     (fifo_full),
      .avail    (frames_avail)
   );

   assign {head_cs, head_id, head_data} = head_frame;

endmodule

// File: rtl/rx_fifo_svc_chk.sv
module rx_fifo_svc_chk #(
   parameter int ID_W    = 29,
   parameter int DEPTH   = 6,
   parameter int TABLE_N = 8,
   parameter int CNT_W   = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    frozen,
   input logic                    cfg_en_we,
   input logic                    cfg_en_val,
   input logic [TABLE_N*ID_W-1:0] acc_ids,
   input logic                    fifo_en,
   input logic                    mv_push,
   input logic                    irq_clr,
   input logic                    frames_avail,
   input logic                    fifo_full,
   input logic [CNT_W-1:0]        occupancy
);

   logic flush_c;
   assign flush_c = frozen && cfg_en_we && !cfg_en_val;

   p_cfg_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !frozen |=> $stable(fifo_en));

   p_tbl_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !frozen |=> $stable(acc_ids));

   p_avail_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_push && fifo_en && !flush_c && !frozen && occupancy == '0) |=> frames_avail);

   p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && frames_avail && !mv_push && !flush_c)
      |=> (occupancy == $past(occupancy) - 1'b1));

   p_empty_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !frames_avail && !mv_push && !flush_c)
      |=> (occupancy == '0 && !frames_avail));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= CNT_W'(DEPTH));

   p_full_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_full) |-> ($past(occupancy) == CNT_W'(DEPTH - 1)));

   p_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && frames_avail && mv_push && fifo_en && !flush_c && !frozen)
      |=> $stable(occupancy));

   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_c |=> (occupancy == '0 && !frames_avail));

endmodule

bind rx_fifo_svc rx_fifo_svc_chk #(
   .ID_W    (ID_W),
   .DEPTH   (DEPTH),
   .TABLE_N (TABLE_N),
   .CNT_W   (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frozen       (frozen),
   .cfg_en_we    (cfg_en_we),
   .cfg_en_val   (cfg_en_val),
   .acc_ids      (acc_ids),
   .fifo_en      (fifo_en),
   .mv_push      (mv_push),
   .irq_clr      (irq_clr),
   .frames_avail (frames_avail),
   .fifo_full    (fifo_full),
   .occupancy    (occupancy)
);

// File: tb/test_rx_fifo_svc.sv
module test_rx_fifo_svc;

   localparam int CS_W = 16, ID_W = 29, DATA_W = 64, DEPTH = 6, TABLE_N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frozen = 1'b0;
   logic cfg_en_we = 1'b0, cfg_en_val = 1'b0, cfg_id_we = 1'b0;
   logic [2:0] cfg_id_sel = '0;
   logic [ID_W-1:0] cfg_id_val = '0;
   logic [TABLE_N*ID_W-1:0] acc_ids;
   logic fifo_en;
   logic mv_push = 1'b0;
   logic [CS_W-1:0] mv_cs = '0;
   logic [ID_W-1:0] mv_id = '0;
   logic [DATA_W-1:0] mv_data = '0;
   logic [CS_W-1:0] head_cs;
   logic [ID_W-1:0] head_id;
   logic [DATA_W-1:0] head_data;
   logic irq_clr = 1'b0;
   logic frames_avail, fifo_full;
   logic [2:0] occupancy;

   int n_run = 0, n_fail = 0;
   int mq [0:255];
   int mh = 0, mcnt = 0, seq = 0;
   bit m_en = 1'b0;
   logic [ID_W-1:0] m_tbl [TABLE_N];

   always #2.5 clk = ~clk;

   rx_fifo_svc i_rx_fifo_svc (
      .clk(clk), .rst_n(rst_n), .frozen(frozen),
      .cfg_en_we(cfg_en_we), .cfg_en_val(cfg_en_val),
      .cfg_id_we(cfg_id_we), .cfg_id_sel(cfg_id_sel), .cfg_id_val(cfg_id_val),
      .acc_ids(acc_ids), .fifo_en(fifo_en),
      .mv_push(mv_push), .mv_cs(mv_cs), .mv_id(mv_id), .mv_data(mv_data),
      .head_cs(head_cs), .head_id(head_id), .head_data(head_data),
      .irq_clr(irq_clr), .frames_avail(frames_avail), .fifo_full(fifo_full),
      .occupancy(occupancy)
   );

   function automatic logic [CS_W-1:0] f_cs(int n);
      return CS_W'(32'hC000 ^ (n * 7));
   endfunction
   function automatic logic [ID_W-1:0] f_id(int n);
      return ID_W'(n * 32'h000B_53C1 + 5);
   endfunction
   function automatic logic [DATA_W-1:0] f_data(int n);
      return {32'(n * 32'h9E37_79B9), ~32'(n)};
   endfunction

   task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   // check all status ports and the head against the reference queue
   task automatic check_state(string tag);
      chk(occupancy == 3'(mcnt), {tag, " occupancy R11"}, occupancy, mcnt);
      chk(frames_avail == (mcnt != 0), {tag, " avail R5"}, frames_avail, mcnt != 0);
      chk(fifo_full == (mcnt == DEPTH), {tag, " full R8"}, fifo_full, mcnt == DEPTH);
      if (mcnt != 0) begin
         chk({head_cs, head_id, head_data} == {f_cs(mq[mh]), f_id(mq[mh]), f_data(mq[mh])},
             {tag, " head order R6"}, {head_cs, head_id, head_data},
             {f_cs(mq[mh]), f_id(mq[mh]), f_data(mq[mh])});
      end
   endtask

   // one cycle of optional move-in and optional interrupt clear
   task automatic cycle(bit p, bit c, string tag);
      bit pop_ok, push_ok;
      mv_push = p; irq_clr = c;
      mv_cs = f_cs(seq); mv_id = f_id(seq); mv_data = f_data(seq);
      pop_ok  = c && mcnt > 0;
      push_ok = p && m_en && (mcnt < DEPTH || pop_ok);
      @(negedge clk);
      mv_push = 1'b0; irq_clr = 1'b0;
      if (pop_ok) begin mh = (mh + 1) % 256; mcnt--; end
      if (push_ok) begin mq[(mh + mcnt) % 256] = seq; mcnt++; end
      seq++;
      check_state(tag);
   endtask

   task automatic write_en(bit v);
      cfg_en_we = 1'b1; cfg_en_val = v;
      if (frozen) begin
         m_en = v;
         if (!v) begin mcnt = 0; mh = 0; end
      end
      @(negedge clk);
      cfg_en_we = 1'b0;
   endtask

   task automatic write_id(int k, logic [ID_W-1:0] v);
      cfg_id_we = 1'b1; cfg_id_sel = 3'(k); cfg_id_val = v;
      if (frozen) m_tbl[k] = v;
      @(negedge clk);
      cfg_id_we = 1'b0;
   endtask

   initial begin
      #(5.0 * 200000);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      for (int k = 0; k < TABLE_N; k++) m_tbl[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(fifo_en == 1'b0, "R1 enable after reset", fifo_en, 0);
      chk(acc_ids == '0, "R1 table after reset", acc_ids, 0);
      check_state("R1");

      // R2: enable write outside freeze ignored
      write_en(1'b1);
      chk(fifo_en == 1'b0, "R2 enable ignored unfrozen", fifo_en, 0);
      // R4: move-in while disabled ignored
      cycle(1'b1, 1'b0, "R4 disabled push");
      frozen = 1'b1;
      write_en(1'b1);
      chk(fifo_en == 1'b1, "R2 enable when frozen", fifo_en, 1);

      // R3: fill every table entry while frozen
      for (int k = 0; k < TABLE_N; k++) write_id(k, ID_W'(k * 32'h0111_1111 + 3));
      frozen = 1'b0;
      write_id(2, 29'h1ABCDEF);
      write_id(7, 29'h0000055);
      for (int k = 0; k < TABLE_N; k++)
         chk(acc_ids[k*ID_W +: ID_W] == m_tbl[k], "R3 table entry",
             acc_ids[k*ID_W +: ID_W], m_tbl[k]);

      // R4/R8/R11: fill to full, then push at full is dropped
      for (int i = 0; i < DEPTH; i++) cycle(1'b1, 1'b0, "R4 fill");
      cycle(1'b1, 1'b0, "R8 push at full dropped");
      // R9 at full
      cycle(1'b1, 1'b1, "R9 both at full");
      // R6 drain in order
      for (int i = 0; i < DEPTH; i++) cycle(1'b0, 1'b1, "R6 drain");
      // R7 clear on empty
      cycle(1'b0, 1'b1, "R7 clear empty");
      cycle(1'b0, 1'b1, "R7 clear empty again");

      // R9 sweep over every level, pointers wrap repeatedly
      for (int lvl = 1; lvl <= DEPTH; lvl++) begin
         while (mcnt < lvl) cycle(1'b1, 1'b0, "R9 sweep fill");
         cycle(1'b1, 1'b1, "R9 both");
         cycle(1'b1, 1'b1, "R9 both twice");
         while (mcnt > 0) cycle(1'b0, 1'b1, "R6 sweep drain");
      end

      // R10: disable while frozen discards contents
      for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, "R10 prefill");
      frozen = 1'b1;
      write_en(1'b0);
      check_state("R10 flush");
      chk(fifo_en == 1'b0, "R10 disabled", fifo_en, 0);
      write_en(1'b1);
      frozen = 1'b0;
      cycle(1'b1, 1'b0, "R10 refill after flush");
      cycle(1'b0, 1'b1, "R10 drain after flush");

      summary();
   end

endmodule